// File: doc/BRIEF.md
# Stream Byte FIFO with Fill Threshold

This block is the small data buffer that sits inside one DMA stream, between the side that fetches from a peripheral and the side that writes to memory. The source side writes items of one, two or four bytes. The memory side reads items of one, two or four bytes. Bytes leave in the order they arrived, so a word written on one side can come out as four bytes on the other side, and the reverse also works. The memory side is told to start a burst only when two conditions hold. The fill level must have reached a programmable fraction of the capacity. The data held must also cover the whole burst that is configured.

A direct mode bypasses the byte buffer. In this mode a single holding slot passes one item at a time, and a request is raised as soon as the slot holds an item. Each mode has its own error flag. In buffered mode, a write that does not fit or a read that asks for more bytes than are held is dropped and raises the FIFO error flag. In direct mode, a write into an occupied slot or a read from an empty slot raises the direct-mode error flag. The block also reports whether the present combination of threshold, burst length and read width is legal.

Top module: `dsf_stream_fifo`

## Requirements
- R1: After reset, and with the stream disabled, the outputs fill_bytes, burst_req, fifo_err, direct_err and rd_valid are all zero.
- R2: Item sizes are coded 0 for 1 byte, 1 for 2 bytes and 2 (or 3) for 4 bytes. Bytes are stored least significant first. A read returns the oldest bytes in its low lanes, and its unused upper lanes are zero.
- R3: In buffered mode, burst_req is asserted only when fill_bytes is at least DEPTH*(thr_sel+1)/4. thr_sel 0 selects one quarter, 1 one half, 2 three quarters and 3 full.
- R4: In buffered mode, burst_req also needs fill_bytes to be at least the burst beat count times the read item size. burst_sel 0 selects a single beat, 1 selects 4 beats, 2 selects 8 beats and 3 selects 16 beats.
- R5: A buffered write whose size exceeds the free space at the start of the cycle is dropped and sets fifo_err. The stored bytes and fill_bytes do not change.
- R6: A buffered read whose size exceeds fill_bytes at the start of the cycle is dropped and sets fifo_err. No rd_valid follows it.
- R7: fifo_err and direct_err stay set while the stream is enabled. Accesses that fit are still carried out after an error.
- R8: While stream_en is low, the contents are emptied: fill_bytes returns to zero, the direct slot empties and both error flags clear. Writes and reads made while stream_en is low have no effect.
- R9: cfg_ok is high in direct mode or with a single-beat burst. Otherwise it is high only if the number of beats held at the threshold, (DEPTH/item size)*(thr_sel+1)/4, is a whole multiple of the burst beat count.
- R10: In direct mode, one item is held in a slot. burst_req is high while the slot is full. A read returns that item masked to the read size. fill_bytes stays zero.
- R11: In direct mode, a write to a full slot (unless a read empties it in the same cycle) or a read from an empty slot is dropped and sets direct_err. fifo_err is not affected.
- R12: An accepted read gives rd_valid high, with rd_data, in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stream_en | input | 1 | Stream enable; low empties the buffer and clears the flags |
| direct_en | input | 1 | Selects direct pass-through instead of buffering |
| thr_sel | input | 2 | Fill threshold select, in quarters of capacity |
| burst_sel | input | 2 | Memory-side burst length select |
| wr_en | input | 1 | Source-side write strobe |
| wr_size | input | 2 | Write item size code |
| wr_data | input | 32 | Write data, least significant byte first |
| rd_en | input | 1 | Memory-side read strobe |
| rd_size | input | 2 | Read item size code, also the burst beat width |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | rd_data holds the result of a read taken last cycle |
| burst_req | output | 1 | Memory side may start a burst |
| fill_bytes | output | clog2(DEPTH+1) | Bytes held in the buffer |
| fifo_err | output | 1 | Buffered overrun or underrun seen |
| direct_err | output | 1 | Direct-mode misuse seen |
| cfg_ok | output | 1 | Threshold, burst and width combination is legal |

## Verification
The bench builds the block with the default capacity of 16 bytes. At that size, one 16-beat byte burst fills the buffer exactly, and the full threshold equals the capacity. This makes the corner between a threshold that is met and a burst that does not yet fit reachable. A short run of word traffic is enough to wrap the read and write pointers several times. With 16 bytes, all 48 combinations of threshold, burst and width can also be swept, so that cfg_ok is compared against a separate divisibility rule.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  // Byte count of an item size code; code 3 is treated as a word.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Beats in one memory-side burst.
  function automatic int unsigned burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  // Bytes the buffer must hold to meet a quarter-granular threshold.
  function automatic int unsigned thr_bytes(input logic [1:0] code, input int unsigned depth);
    return (depth * (int'(code) + 1)) / 4;
  endfunction

  // A threshold is usable when the beats held there form whole bursts.
  function automatic logic thr_legal(input logic [1:0] thr, input logic [1:0] burst,
                                     input logic [1:0] size, input int unsigned depth);
    int unsigned held;
    if (burst == 2'd0) return 1'b1;
    held = ((depth / int'(size_bytes(size))) * (int'(thr) + 1)) / 4;
    return (held % burst_beats(burst)) == 0;
  endfunction

  // Zero the lanes above the item size.
  function automatic logic [31:0] mask_item(input logic [31:0] d, input logic [2:0] n);
    case (n)
      3'd1:    return {24'd0, d[7:0]};
      3'd2:    return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dsf_byte_ring.sv
module dsf_byte_ring #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_go,
  input  logic [2:0]       wr_n,
  input  logic [31:0]      wr_data,
  input  logic             rd_go,
  input  logic [2:0]       rd_n,
  output logic [31:0]      rd_word,
  output logic [LVL_W-1:0] level
);
  localparam int LANES = 4;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wp;
  logic [PTR_W-1:0] rp;

  // Byte lanes land at consecutive addresses, wrapping at the end.
  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int k = 0; k < LANES; k++) begin
        if (3'(k) < wr_n) mem[wp + PTR_W'(k)] <= wr_data[8*k +: 8];
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd_lane
    assign rd_word[8*k +: 8] = mem[rp + PTR_W'(k)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clear) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_go) wp <= wp + PTR_W'(wr_n);
      if (rd_go) rp <= rp + PTR_W'(rd_n);
      level <= level + (wr_go ? LVL_W'(wr_n) : '0) - (rd_go ? LVL_W'(rd_n) : '0);
    end
  end
endmodule

// File: rtl/dsf_direct_slot.sv
module dsf_direct_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic          take,
  input  logic [DW-1:0] load_data,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (clear) begin
      full <= 1'b0;
    end else begin
      if (load) begin
        full <= 1'b1;
        data <= load_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsf_req_ctrl.sv
module dsf_req_ctrl
  import dsf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             buf_active,
  input  logic             dir_active,
  input  logic             direct_en,
  input  logic             slot_full,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       thr_sel,
  input  logic [1:0]       burst_sel,
  input  logic [1:0]       rd_size,
  output logic [LVL_W-1:0] thr_need,
  output logic             burst_req,
  output logic             cfg_ok
);
  int unsigned burst_need;
  logic        thr_met;
  logic        burst_fits;

  assign thr_need   = LVL_W'(thr_bytes(thr_sel, DEPTH));
  assign burst_need = burst_beats(burst_sel) * int'(size_bytes(rd_size));
  assign thr_met    = level >= thr_need;
  assign burst_fits = 32'(level) >= burst_need;

  always_comb begin
    if (dir_active)      burst_req = slot_full;
    else if (buf_active) burst_req = thr_met && burst_fits;
    else                 burst_req = 1'b0;
  end

  assign cfg_ok = direct_en || thr_legal(thr_sel, burst_sel, rd_size, DEPTH);
endmodule

// File: rtl/dsf_stream_fifo.sv
module dsf_stream_fifo
  import dsf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stream_en,
  input  logic             direct_en,
  input  logic [1:0]       thr_sel,
  input  logic [1:0]       burst_sel,
  input  logic             wr_en,
  input  logic [1:0]       wr_size,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_size,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             burst_req,
  output logic [LVL_W-1:0] fill_bytes,
  output logic             fifo_err,
  output logic             direct_err,
  output logic             cfg_ok
);
  localparam int PTR_W = $clog2(DEPTH);

  // Named internal events, used by the checker.
  logic [2:0]       wr_n, rd_n;
  logic [LVL_W-1:0] free_bytes;
  logic             buf_active, dir_active;
  logic             wr_accept, wr_overrun;
  logic             rd_accept, rd_underrun;
  logic             slot_full;
  logic [31:0]      slot_data;
  logic             dm_rd_ok, dm_rd_bad, dm_wr_ok, dm_wr_bad, dm_bad;
  logic [31:0]      ring_word;
  logic [LVL_W-1:0] thr_need;

  assign wr_n       = size_bytes(wr_size);
  assign rd_n       = size_bytes(rd_size);
  assign buf_active = stream_en && !direct_en;
  assign dir_active = stream_en && direct_en;
  assign free_bytes = LVL_W'(DEPTH) - fill_bytes;

  // Space and data are judged on the level at the start of the cycle.
  assign wr_accept   = buf_active && wr_en && (free_bytes >= LVL_W'(wr_n));
  assign wr_overrun  = buf_active && wr_en && (free_bytes <  LVL_W'(wr_n));
  assign rd_accept   = buf_active && rd_en && (fill_bytes >= LVL_W'(rd_n));
  assign rd_underrun = buf_active && rd_en && (fill_bytes <  LVL_W'(rd_n));

  assign dm_rd_ok  = dir_active && rd_en && slot_full;
  assign dm_rd_bad = dir_active && rd_en && !slot_full;
  assign dm_wr_ok  = dir_active && wr_en && (!slot_full || dm_rd_ok);
  assign dm_wr_bad = dir_active && wr_en && slot_full && !dm_rd_ok;
  assign dm_bad    = dm_rd_bad || dm_wr_bad;

  dsf_byte_ring #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!stream_en),
    .wr_go   (wr_accept),
    .wr_n    (wr_n),
    .wr_data (wr_data),
    .rd_go   (rd_accept),
    .rd_n    (rd_n),
    .rd_word (ring_word),
    .level   (fill_bytes)
  );

  dsf_direct_slot #(.DW(32)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!stream_en),
    .load      (dm_wr_ok),
    .take      (dm_rd_ok),
    .load_data (wr_data),
    .full      (slot_full),
    .data      (slot_data)
  );

  dsf_req_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_req (
    .buf_active (buf_active),
    .dir_active (dir_active),
    .direct_en  (direct_en),
    .slot_full  (slot_full),
    .level      (fill_bytes),
    .thr_sel    (thr_sel),
    .burst_sel  (burst_sel),
    .rd_size    (rd_size),
    .thr_need   (thr_need),
    .burst_req  (burst_req),
    .cfg_ok     (cfg_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_accept || dm_rd_ok;
      if (rd_accept)     rd_data <= mask_item(ring_word, rd_n);
      else if (dm_rd_ok) rd_data <= mask_item(slot_data, rd_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_err   <= 1'b0;
      direct_err <= 1'b0;
    end else if (!stream_en) begin
      fifo_err   <= 1'b0;
      direct_err <= 1'b0;
    end else begin
      if (wr_overrun || rd_underrun) fifo_err   <= 1'b1;
      if (dm_bad)                    direct_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dsf_stream_fifo_chk.sv
module dsf_stream_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stream_en,
  input logic             direct_en,
  input logic             wr_overrun,
  input logic             rd_underrun,
  input logic             rd_accept,
  input logic             dm_bad,
  input logic [LVL_W-1:0] level,
  input logic [LVL_W-1:0] thr_need,
  input logic             burst_req,
  input logic             fifo_err,
  input logic             direct_err,
  input logic             rd_valid
);
  // R5
  overrun_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overrun |=> fifo_err);

  // R6
  underrun_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_underrun |=> fifo_err);

  // R12
  read_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> rd_valid);

  // R8
  disable_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |=> (level == '0 && !fifo_err && !direct_err));

  // R3
  burst_needs_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && !direct_en) |-> (level >= thr_need));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_en && fifo_err) |=> fifo_err);

  // R11
  direct_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_bad |=> direct_err);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
endmodule

bind dsf_stream_fifo dsf_stream_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stream_en   (stream_en),
  .direct_en   (direct_en),
  .wr_overrun  (wr_overrun),
  .rd_underrun (rd_underrun),
  .rd_accept   (rd_accept),
  .dm_bad      (dm_bad),
  .level       (fill_bytes),
  .thr_need    (thr_need),
  .burst_req   (burst_req),
  .fifo_err    (fifo_err),
  .direct_err  (direct_err),
  .rd_valid    (rd_valid)
);

// File: tb/dsf_stream_fifo_tb.sv
`timescale 1ns/1ps
module dsf_stream_fifo_tb;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stream_en = 1'b0, direct_en = 1'b0;
  logic [1:0] thr_sel = '0, burst_sel = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_size = '0, rd_size = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rd_valid, burst_req, fifo_err, direct_err, cfg_ok;
  logic [LVL_W-1:0] fill_bytes;

  always #2 clk = ~clk;

  dsf_stream_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .direct_en(direct_en),
    .thr_sel(thr_sel), .burst_sel(burst_sel), .wr_en(wr_en), .wr_size(wr_size),
    .wr_data(wr_data), .rd_en(rd_en), .rd_size(rd_size), .rd_data(rd_data),
    .rd_valid(rd_valid), .burst_req(burst_req), .fill_bytes(fill_bytes),
    .fifo_err(fifo_err), .direct_err(direct_err), .cfg_ok(cfg_ok)
  );

  // Reference model state
  byte unsigned mq[$];
  logic [31:0]  exp_q[$];
  bit           m_ferr, m_derr, slot_v;
  logic [31:0]  slot_d;
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic int beats(input logic [1:0] b);
    return (b == 2'd0) ? 1 : (4 << (int'(b) - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every rd_valid must match the oldest expected item (R12, R2).
  always @(negedge clk) begin
    if (rst_n && rd_valid && !done) begin
      logic [31:0] e;
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected rd_valid", rd_data, 0);
      else begin
        e = exp_q.pop_front();
        chk(rd_data == e, "R2 R12 read data", rd_data, e);
      end
    end
  end

  task automatic model_step(input bit we, input logic [1:0] ws, input logic [31:0] wd,
                            input bit re, input logic [1:0] rs);
    int lvl0;
    logic [31:0] v;
    if (!stream_en) return;
    if (direct_en) begin
      bit ro;
      ro = re && slot_v;
      if (re && !slot_v) m_derr = 1;
      if (we && slot_v && !ro) m_derr = 1;
      if (ro) begin
        v = slot_d;
        if (nb(rs) == 1) v = v & 32'hFF;
        else if (nb(rs) == 2) v = v & 32'hFFFF;
        exp_q.push_back(v);
        slot_v = 0;
      end
      if (we && (!slot_v || ro)) begin
        slot_v = 1;
        slot_d = wd;
      end
    end else begin
      lvl0 = mq.size();
      if (re) begin
        if (lvl0 >= nb(rs)) begin
          v = '0;
          for (int k = 0; k < nb(rs); k++) v[8*k +: 8] = mq.pop_front();
          exp_q.push_back(v);
        end else m_ferr = 1;
      end
      if (we) begin
        if (DEPTH - lvl0 >= nb(ws)) begin
          for (int k = 0; k < nb(ws); k++) mq.push_back(wd[8*k +: 8]);
        end else m_ferr = 1;
      end
    end
  endtask

  task automatic check_state(input string req);
    bit eb;
    int l;
    l = mq.size();
    if (!stream_en) eb = 0;
    else if (direct_en) eb = slot_v;
    else eb = (4 * l >= DEPTH * (int'(thr_sel) + 1)) && (l >= beats(burst_sel) * nb(rd_size));
    chk(int'(fill_bytes) == l, {req, " fill"}, fill_bytes, l);
    chk(burst_req == eb, {req, " R3 R4 burst_req"}, burst_req, eb);
    chk(fifo_err == m_ferr, {req, " fifo_err"}, fifo_err, m_ferr);
    chk(direct_err == m_derr, {req, " direct_err"}, direct_err, m_derr);
  endtask

  task automatic op(input bit we, input logic [1:0] ws, input logic [31:0] wd,
                    input bit re, input logic [1:0] rs, input string req);
    wr_en = we; wr_size = ws; wr_data = wd; rd_en = re; rd_size = rs;
    @(posedge clk);
    model_step(we, ws, wd, re, rs);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check_state(req);
  endtask

  task automatic set_en(input bit en, input bit dir, input string req);
    stream_en = en; direct_en = dir;
    @(posedge clk);
    if (!en) begin
      mq.delete(); m_ferr = 0; m_derr = 0; slot_v = 0;
    end
    @(negedge clk);
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fill_bytes == 0, "R1 fill", fill_bytes, 0);
    chk(burst_req == 0, "R1 burst_req", burst_req, 0);
    chk(fifo_err == 0 && direct_err == 0, "R1 errors", {fifo_err, direct_err}, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);

    thr_sel = 2'd1; burst_sel = 2'd1; rd_size = 2'd2;
    set_en(1, 0, "R8 enable");
    // R2 byte packing, R3/R4 request
    op(1, 0, 32'h11, 0, 2, "R2 wr byte");
    op(1, 0, 32'h22, 0, 2, "R2 wr byte");
    op(1, 0, 32'h33, 0, 2, "R2 wr byte");
    op(1, 0, 32'h44, 0, 2, "R2 wr byte");
    op(1, 2, 32'h88776655, 0, 2, "R4 thr met burst short");
    op(1, 2, 32'hCCBBAA99, 0, 2, "R4 wr word");
    op(1, 2, 32'h00FFEEDD, 0, 2, "R3 R4 full");
    // R5 overrun
    op(1, 0, 32'h5A, 0, 2, "R5 overrun");
    // R7 continue after error, R2 mixed reads
    op(0, 0, 0, 1, 2, "R7 R2 rd word");
    op(0, 0, 0, 1, 1, "R2 rd half");
    op(0, 0, 0, 1, 0, "R2 rd byte");
    op(0, 0, 0, 1, 0, "R2 rd byte");
    op(1, 1, 32'hBEEF, 0, 2, "R7 wr after err");
    op(1, 0, 32'h77, 1, 2, "R2 wr rd same cycle");
    // R8 disable
    set_en(0, 0, "R8 disable");
    op(1, 2, 32'h01020304, 0, 2, "R8 wr ignored");
    op(0, 0, 0, 1, 0, "R8 rd ignored");
    set_en(1, 0, "R8 reenable");
    // R6 underrun
    op(1, 1, 32'h1234, 0, 2, "R6 setup");
    op(0, 0, 0, 1, 2, "R6 underrun");
    op(0, 0, 0, 1, 1, "R6 R7 rd half");
    // wrap-around traffic
    for (int i = 0; i < 10; i++) begin
      op(1, 2, 32'hA0B0C0D0 + i, 0, 2, "R2 wrap wr");
      op(1, 1, 32'h5500 + i, 1, 0, "R2 wrap mix");
      op(0, 0, 0, 1, 1, "R2 wrap rd");
      op(0, 0, 0, 1, 0, "R2 wrap rd");
      op(0, 0, 0, 1, 1, "R2 wrap rd");
    end
    // R3 threshold sweep with single beats
    burst_sel = 2'd0;
    for (int t = 0; t < 4; t++) begin
      thr_sel = 2'(t);
      set_en(0, 0, "R8 disable");
      set_en(1, 0, "R8 enable");
      for (int b = 0; b < DEPTH; b++) op(1, 0, 32'(b), 0, 0, "R3 thr sweep");
    end
    // R4 long burst, low threshold
    thr_sel = 2'd0; burst_sel = 2'd3; rd_size = 2'd0;
    set_en(0, 0, "R8 disable");
    set_en(1, 0, "R8 enable");
    for (int b = 0; b < DEPTH; b++) op(1, 0, 32'(b), 0, 0, "R4 16 beat");
    for (int b = 0; b < DEPTH; b++) op(0, 0, 0, 1, 0, "R4 drain");
    // R9 legality sweep
    for (int t = 0; t < 4; t++)
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 3; s++) begin
          bit e;
          thr_sel = 2'(t); burst_sel = 2'(b); rd_size = 2'(s);
          #1;
          e = (b == 0) || (((DEPTH * (t + 1) / 4) % (beats(2'(b)) * nb(2'(s)))) == 0);
          chk(cfg_ok == e, "R9 cfg_ok", cfg_ok, e);
        end
    // R10 / R11 direct mode
    set_en(0, 0, "R8 disable");
    set_en(1, 1, "R10 direct on");
    chk(cfg_ok == 1, "R9 R10 cfg_ok direct", cfg_ok, 1);
    op(1, 2, 32'hDEADBEEF, 0, 2, "R10 load slot");
    op(1, 2, 32'h00000001, 0, 2, "R11 write full slot");
    op(0, 0, 0, 1, 2, "R10 read slot");
    op(0, 0, 0, 1, 2, "R11 read empty");
    op(1, 2, 32'hA5A5C3C3, 0, 2, "R10 load");
    op(1, 2, 32'h13579BDF, 1, 1, "R10 read and load");
    op(0, 0, 0, 1, 0, "R10 read byte");
    set_en(0, 0, "R8 disable direct");

    @(negedge clk);
    chk(exp_q.size() == 0, "R12 missing reads", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule